// File: doc/BRIEF.md
# JTAG TMS Chain Sequencer

This block turns a stream of command bytes into activity on a four-bit JTAG port. It drives TCK, TMS and TDI and samples TDO. A host pushes bytes over a valid/ready byte interface, for example from a buffered endpoint. The first byte of each command is an opcode, and it is followed by argument bytes.

The main command is the chained TMS move. The host sends one opcode and a count byte, then that many TMS pattern bytes. The sequencer plays all the patterns out as one uninterrupted burst of TAP state moves, with no idle time between patterns. The block also supports:
- a single TMS pattern move;
- a run of idle TCK pulses;
- a one-byte TDI shift that returns the TDO bits it captured.

TCK comes from a divider of the system clock, and the divider ratio is set by an input. The number of TMS bits taken from each pattern byte is given by a 3-bit step input, which is sampled together with that byte.

Top module: `jtag_tms_seq`

## Requirements
- R1: After reset, `jtag_out` is 0000, `busy` is 0, `cmd_ready` is 1 and `rsp_valid` is 0.
- R2: `jtag_out` bit 1 carries TMS, bit 2 carries TCK and bit 3 carries TDI. Bit 0 is the TDO position: it is driven 0, and TDO enters on `tdo_i`.
- R3: Opcode 0x09 followed by one pattern byte plays the pattern least-significant bit first, with one TMS value per TCK period and TDI at 0. TMS and TDI change only while TCK is low (at its falling edge) and hold steady while TCK is high.
- R4: The `tms_steps` value sampled with a pattern byte gives the number of bits played from that byte (1 to 7). A value of 0 selects 7 bits.
- R5: Opcode 0x0A, then a count byte N, then N pattern bytes: the patterns play in order, back to back. Inside the burst, every TCK low phase lasts exactly `clk_div`+1 clocks, including the phase between the last bit of one pattern and the first bit of the next.
- R6: Chain counts up to 64 are honoured. A larger count is clamped to 64: exactly 64 pattern bytes are consumed, and the byte after them is decoded as an opcode.
- R7: A chain count of 0 completes at once with no TCK activity, and the next byte is decoded as an opcode.
- R8: Opcode 0x0C followed by a count N produces N TCK pulses with TMS and TDI at 0. N = 0 produces no pulse.
- R9: Opcode 0x08 followed by a data byte shifts the byte onto TDI least-significant bit first, with TMS at 0, and samples `tdo_i` at each TCK rising edge. `rsp_valid` then pulses for one clock with `rsp_data` holding the captured bits, the first sample in bit 0.
- R10: Each TCK high phase and each low phase inside a command lasts `clk_div`+1 clock cycles.
- R11: Any opcode other than 0x08, 0x09, 0x0A and 0x0C is consumed without TCK activity and without a response.
- R12: `busy` is high from the acceptance of an opcode that takes arguments until the falling TCK edge of the command's last bit. TCK is low whenever `busy` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Command byte present |
| cmd_data | input | 8 | Command byte |
| cmd_ready | output | 1 | Sequencer takes the byte on this clock |
| tms_steps | input | 3 | TMS bits to use from the current pattern byte (0 means 7) |
| clk_div | input | DIV_W | TCK phase length minus one, in clocks; change only while idle |
| tdo_i | input | 1 | TDO from the scan chain |
| jtag_out | output | 4 | {TDI, TCK, TMS, 0} |
| busy | output | 1 | A command is in progress |
| rsp_valid | output | 1 | One-clock pulse: a captured byte is available |
| rsp_data | output | 8 | Captured TDO byte |

## Verification
The chained move is tried with three patterns of different step counts, with a full chain of 64 one-bit patterns at the fastest divider setting, and with an oversized count of 70. These cases tell apart per-byte step handling, gap-free hand-over between patterns, and the clamp of the count. A chain count of zero is followed at once by a single move, which shows that no pulses were emitted and that decoding returned to opcodes. A shift with a known TDO pattern, idle runs of five and zero pulses, and a string of unknown opcodes separate data capture, pure clocking and silent consumption. Phase lengths are measured at two divider settings.

// File: rtl/jtag_seq_pkg.sv
// Shared opcodes, state encodings and the job record that passes between
// the byte decoder and the bit engine.
package jtag_seq_pkg;

    localparam logic [7:0] OP_SHIFT     = 8'h08;
    localparam logic [7:0] OP_TMS       = 8'h09;
    localparam logic [7:0] OP_TMS_CHAIN = 8'h0A;
    localparam logic [7:0] OP_IDLE      = 8'h0C;

    typedef enum logic [1:0] {
        PS_OP,
        PS_ARG,
        PS_CHAIN
    } parse_st_t;

    typedef enum logic [1:0] {
        EN_IDLE,
        EN_LOW,
        EN_HIGH
    } eng_st_t;

    // One burst of TCK periods: bit i of tms/tdi is applied in period i
    // (taken modulo 8). nbits is never 0.
    typedef struct packed {
        logic [7:0] tms;
        logic [7:0] tdi;
        logic [7:0] nbits;
        logic       capture;
    } jtag_job_t;

endpackage

// File: rtl/jtag_tck_divider.sv
// Phase timer for TCK. While run is high, tick pulses once every
// clk_div+1 clocks. The count restarts from zero whenever run is low.
// Assumes clk_div changes only while run is low.
module jtag_tck_divider #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] clk_div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt;

    assign tick = run && (cnt >= clk_div);

    // Count clocks within the current TCK phase.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/jtag_cmd_parser.sv
// Byte decoder. It consumes opcodes and their arguments, and posts one
// job at a time into a single-entry slot that the bit engine drains.
// Unknown opcodes are dropped. Chain counts above CHAIN_MAX are clamped.
// Assumes the engine takes the slot by raising job_take.
module jtag_cmd_parser
    import jtag_seq_pkg::*;
#(
    parameter int CHAIN_MAX = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cmd_valid,
    input  logic [7:0] cmd_data,
    input  logic [2:0] tms_steps,
    input  logic       job_take,
    output logic       cmd_ready,
    output logic       job_valid,
    output jtag_job_t  job,
    output logic       pending
);

    localparam int REM_W = $clog2(CHAIN_MAX + 1);

    parse_st_t        ps;
    logic [7:0]       op_q;
    logic [REM_W-1:0] remain;
    logic [7:0]       steps_n;
    logic             accept;

    assign cmd_ready = (ps == PS_OP) || !job_valid;
    assign accept    = cmd_valid && cmd_ready;
    assign pending   = (ps != PS_OP);

    // Map the step input to a bit count; 0 selects the default of 7.
    always_comb begin
        steps_n = (tms_steps == 3'd0) ? 8'd7 : {5'd0, tms_steps};
    end

    // Decode bytes and fill the job slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ps        <= PS_OP;
            op_q      <= '0;
            remain    <= '0;
            job_valid <= 1'b0;
            job       <= '0;
        end else begin
            if (job_valid && job_take) begin
                job_valid <= 1'b0;
            end
            if (accept) begin
                case (ps)
                    PS_OP: begin
                        op_q <= cmd_data;
                        if (cmd_data == OP_TMS || cmd_data == OP_TMS_CHAIN ||
                            cmd_data == OP_SHIFT || cmd_data == OP_IDLE) begin
                            ps <= PS_ARG;
                        end
                    end
                    PS_ARG: begin
                        ps <= PS_OP;
                        case (op_q)
                            OP_TMS: begin
                                job_valid <= 1'b1;
                                job       <= '{tms: cmd_data, tdi: 8'd0,
                                               nbits: steps_n, capture: 1'b0};
                            end
                            OP_SHIFT: begin
                                job_valid <= 1'b1;
                                job       <= '{tms: 8'd0, tdi: cmd_data,
                                               nbits: 8'd8, capture: 1'b1};
                            end
                            OP_IDLE: begin
                                if (cmd_data != 8'd0) begin
                                    job_valid <= 1'b1;
                                    job       <= '{tms: 8'd0, tdi: 8'd0,
                                                   nbits: cmd_data, capture: 1'b0};
                                end
                            end
                            default: begin
                                if (cmd_data != 8'd0) begin
                                    ps     <= PS_CHAIN;
                                    remain <= (cmd_data > CHAIN_MAX) ?
                                              REM_W'(CHAIN_MAX) : REM_W'(cmd_data);
                                end
                            end
                        endcase
                    end
                    default: begin
                        job_valid <= 1'b1;
                        job       <= '{tms: cmd_data, tdi: 8'd0,
                                       nbits: steps_n, capture: 1'b0};
                        remain    <= remain - 1'b1;
                        if (remain == REM_W'(1)) begin
                            ps <= PS_OP;
                        end
                    end
                endcase
            end
        end
    end

    AST_CHAIN_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        remain <= REM_W'(CHAIN_MAX)); // R6
    AST_SLOT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (job_valid && !job_take) |=> (job_valid && $stable(job))); // R5
    AST_NO_EMPTY_JOB: assert property (@(posedge clk) disable iff (!rst_n)
        job_valid |-> (job.nbits != 8'd0)); // R7

endmodule

// File: rtl/jtag_bit_engine.sv
// Plays one job as a train of TCK periods. Each period has a low phase and
// then a high phase, and each phase ends on a divider tick. TMS and TDI
// move only at the falling edge. TDO is sampled on the clock that raises
// TCK. When a job ends and another is waiting, the next one starts with no
// idle gap. Assumes job_valid stays high until job_ready takes the job.
module jtag_bit_engine
    import jtag_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       job_valid,
    input  jtag_job_t  job,
    input  logic       tick,
    input  logic       tdo_i,
    output logic       job_ready,
    output logic       active,
    output logic       tck,
    output logic       tms,
    output logic       tdi,
    output logic       rsp_valid,
    output logic [7:0] rsp_data
);

    eng_st_t    st;
    jtag_job_t  job_q;
    logic [7:0] idx;
    logic [7:0] idx_nx;
    logic [7:0] cap;
    logic       last;
    logic       finish;

    // Detect the end of the final high phase of the current job.
    always_comb begin
        idx_nx = idx + 8'd1;
        last   = (idx_nx == job_q.nbits);
        finish = (st == EN_HIGH) && tick && last;
    end

    assign job_ready = (st == EN_IDLE) || finish;
    assign active    = (st != EN_IDLE);

    // Step through the phases and load jobs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st        <= EN_IDLE;
            job_q     <= '0;
            idx       <= '0;
            cap       <= '0;
            tck       <= 1'b0;
            tms       <= 1'b0;
            tdi       <= 1'b0;
            rsp_valid <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= finish && job_q.capture;
            if (finish) begin
                rsp_data <= cap;
            end
            if (job_valid && job_ready) begin
                st    <= EN_LOW;
                job_q <= job;
                idx   <= '0;
                cap   <= '0;
                tck   <= 1'b0;
                tms   <= job.tms[0];
                tdi   <= job.tdi[0];
            end else begin
                case (st)
                    EN_LOW: begin
                        if (tick) begin
                            st  <= EN_HIGH;
                            tck <= 1'b1;
                            cap <= {tdo_i, cap[7:1]};
                        end
                    end
                    EN_HIGH: begin
                        if (tick) begin
                            tck <= 1'b0;
                            if (last) begin
                                st <= EN_IDLE;
                            end else begin
                                st  <= EN_LOW;
                                idx <= idx_nx;
                                tms <= job_q.tms[idx_nx[2:0]];
                                tdi <= job_q.tdi[idx_nx[2:0]];
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    AST_TMS_STABLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (tck && $past(tck)) |-> ($stable(tms) && $stable(tdi))); // R3
    AST_IDX_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> (idx < job_q.nbits)); // R4
    AST_RSP_AFTER_FALL: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> (!tck && $past(tck))); // R9
    AST_RISE_WHEN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tck) |-> active); // R10

endmodule

// File: rtl/jtag_tms_seq.sv
// Top of the byte-command JTAG sequencer. It joins the decoder, the phase
// timer and the bit engine, and packs the pins into the four-bit port
// {TDI, TCK, TMS, 0}. Assumes clk_div is changed only while busy is low.
module jtag_tms_seq
    import jtag_seq_pkg::*;
#(
    parameter int DIV_W     = 8,
    parameter int CHAIN_MAX = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_data,
    output logic             cmd_ready,
    input  logic [2:0]       tms_steps,
    input  logic [DIV_W-1:0] clk_div,
    input  logic             tdo_i,
    output logic [3:0]       jtag_out,
    output logic             busy,
    output logic             rsp_valid,
    output logic [7:0]       rsp_data
);

    logic      job_valid;
    logic      job_ready;
    jtag_job_t job;
    logic      pending;
    logic      active;
    logic      tick;
    logic      tck;
    logic      tms;
    logic      tdi;

    jtag_cmd_parser #(.CHAIN_MAX(CHAIN_MAX)) u_parser (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .tms_steps (tms_steps),
        .job_take  (job_ready),
        .cmd_ready (cmd_ready),
        .job_valid (job_valid),
        .job       (job),
        .pending   (pending)
    );

    jtag_tck_divider #(.DIV_W(DIV_W)) u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (active),
        .clk_div (clk_div),
        .tick    (tick)
    );

    jtag_bit_engine u_engine (
        .clk       (clk),
        .rst_n     (rst_n),
        .job_valid (job_valid),
        .job       (job),
        .tick      (tick),
        .tdo_i     (tdo_i),
        .job_ready (job_ready),
        .active    (active),
        .tck       (tck),
        .tms       (tms),
        .tdi       (tdi),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    assign jtag_out = {tdi, tck, tms, 1'b0};
    assign busy     = pending || job_valid || active;

    AST_IDLE_TCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !jtag_out[2]); // R12

endmodule

// File: tb/jtag_tms_seq_test.sv
module jtag_tms_seq_test;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       cmd_valid;
    logic [7:0] cmd_data;
    logic       cmd_ready;
    logic [2:0] tms_steps;
    logic [7:0] clk_div;
    logic       tdo_i;
    logic [3:0] jtag_out;
    logic       busy;
    logic       rsp_valid;
    logic [7:0] rsp_data;

    always #(CLK_PERIOD / 2) clk = ~clk;

    jtag_tms_seq uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_data  (cmd_data),
        .cmd_ready (cmd_ready),
        .tms_steps (tms_steps),
        .clk_div   (clk_div),
        .tdo_i     (tdo_i),
        .jtag_out  (jtag_out),
        .busy      (busy),
        .rsp_valid (rsp_valid),
        .rsp_data  (rsp_data)
    );

    int         n_vec = 0;
    int         n_bad = 0;
    string      req = "R1";
    logic [2:0] expq[$];          // {contig, tdi, tms}, one per expected rise
    int         rises = 0;
    int         rise_base = 0;
    int         rsp_count = 0;
    logic [7:0] rsp_last = '0;
    logic [7:0] tdo_pat = 8'h00;
    logic       prev_tck = 1'b0;
    int         run = 0;
    logic       tms_hold = 1'b0;
    logic       tdi_hold = 1'b0;
    bit         finished = 1'b0;

    task automatic chk(input bit ok, input string r, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", r, what, act, exp);
        end
    endtask

    // Reference model: expected pin values at each TCK rise, phase timing.
    always @(negedge clk) begin
        logic tck;
        logic [2:0] e;
        tck = jtag_out[2];
        tdo_i = tdo_pat[(rises - rise_base) % 8];
        if (rst_n) begin
            if (tck && !prev_tck) begin
                rises++;
                chk(jtag_out[0] == 1'b0, "R2", "port bit0", int'(jtag_out[0]), 0);
                if (expq.size() == 0) begin
                    chk(1'b0, req, "unexpected TCK rise", 1, 0);
                end else begin
                    e = expq.pop_front();
                    chk(jtag_out[1] == e[0], req, "TMS at rise", int'(jtag_out[1]), int'(e[0]));
                    chk(jtag_out[3] == e[1], req, "TDI at rise", int'(jtag_out[3]), int'(e[1]));
                    if (e[2]) begin
                        chk(run == int'(clk_div) + 1, "R5", "low phase in burst", run, int'(clk_div) + 1);
                    end
                end
                tms_hold = jtag_out[1];
                tdi_hold = jtag_out[3];
                tdo_i = tdo_pat[(rises - rise_base) % 8];
                run = 1;
            end else if (!tck && prev_tck) begin
                chk(run == int'(clk_div) + 1, "R10", "high phase", run, int'(clk_div) + 1);
                run = 1;
            end else begin
                run++;
                if (tck) begin
                    chk(jtag_out[1] == tms_hold && jtag_out[3] == tdi_hold, "R3",
                        "TMS/TDI moved while TCK high", int'(jtag_out[1]), int'(tms_hold));
                end
            end
            if (!busy && tck) begin
                chk(1'b0, "R12", "TCK high while not busy", 1, 0);
            end
            if (rsp_valid) begin
                rsp_count++;
                rsp_last = rsp_data;
            end
        end
        prev_tck = tck;
    end

    // Present one byte; returns on the negedge after it was taken.
    task automatic send(input logic [7:0] b, input logic [2:0] s);
        cmd_valid = 1'b1;
        cmd_data  = b;
        tms_steps = s;
        while (!cmd_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic push_bits(input logic [7:0] tmsb, input logic [7:0] tdib,
                             input int n, input bit contig_first);
        for (int i = 0; i < n; i++) begin
            expq.push_back({(i > 0) || contig_first, tdib[i % 8], tmsb[i % 8]});
        end
    endtask

    task automatic wait_done();
        cmd_valid = 1'b0;
        repeat (2) @(negedge clk);
        while (busy) @(negedge clk);
        repeat (2) @(negedge clk);
        chk(expq.size() == 0, req, "bits not played", expq.size(), 0);
    endtask

    task automatic report();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        int r0;
        int c0;
        rst_n     = 1'b0;
        cmd_valid = 1'b0;
        cmd_data  = '0;
        tms_steps = '0;
        clk_div   = 8'd0;
        tdo_i     = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        req = "R1";
        chk(jtag_out == 4'b0000, "R1", "port after reset", int'(jtag_out), 0);
        chk(busy == 1'b0, "R1", "busy after reset", int'(busy), 0);
        chk(cmd_ready == 1'b1, "R1", "ready after reset", int'(cmd_ready), 1);
        chk(rsp_valid == 1'b0, "R1", "rsp after reset", int'(rsp_valid), 0);

        // R3: single move, default 7 steps; R12 busy after opcode
        req = "R3";
        r0 = rises;
        push_bits(8'h6D, 8'h00, 7, 1'b0);
        send(8'h09, 3'd0);
        chk(busy == 1'b1, "R12", "busy after opcode", int'(busy), 1);
        send(8'h6D, 3'd0);
        wait_done();
        chk(rises - r0 == 7, "R4", "default step count", rises - r0, 7);

        // R4/R10: three steps at a slower divider
        req = "R4";
        clk_div = 8'd2;
        r0 = rises;
        push_bits(8'hFF, 8'h00, 3, 1'b0);
        send(8'h09, 3'd0);
        send(8'hFF, 3'd3);
        wait_done();
        chk(rises - r0 == 3, "R4", "three steps", rises - r0, 3);

        // R5: chain of three patterns with different step counts
        req = "R5";
        clk_div = 8'd1;
        push_bits(8'h1F, 8'h00, 5, 1'b0);
        push_bits(8'h02, 8'h00, 2, 1'b1);
        push_bits(8'h55, 8'h00, 7, 1'b1);
        send(8'h0A, 3'd0);
        send(8'd3, 3'd0);
        send(8'h1F, 3'd5);
        send(8'h02, 3'd2);
        send(8'h55, 3'd0);
        wait_done();

        // R7: zero-length chain, then a one-bit move
        req = "R7";
        r0 = rises;
        push_bits(8'h01, 8'h00, 1, 1'b0);
        send(8'h0A, 3'd0);
        send(8'd0, 3'd0);
        send(8'h09, 3'd0);
        send(8'h01, 3'd1);
        wait_done();
        chk(rises - r0 == 1, "R7", "pulses after empty chain", rises - r0, 1);

        // R6: full chain of 64 one-bit patterns at the fastest rate
        req = "R6";
        clk_div = 8'd0;
        r0 = rises;
        send(8'h0A, 3'd0);
        send(8'd64, 3'd0);
        for (int i = 0; i < 64; i++) begin
            push_bits({7'd0, i[0]}, 8'h00, 1, i > 0);
            send({7'd0, i[0]}, 3'd1);
        end
        wait_done();
        chk(rises - r0 == 64, "R6", "pulses for 64-byte chain", rises - r0, 64);

        // R6: count 70 is clamped; the byte after 64 patterns is an opcode
        r0 = rises;
        send(8'h0A, 3'd0);
        send(8'd70, 3'd0);
        for (int i = 0; i < 64; i++) begin
            push_bits(i[7:0], 8'h00, 2, i > 0);
            send(i[7:0], 3'd2);
        end
        push_bits(8'h00, 8'h00, 2, 1'b0);
        send(8'h0C, 3'd0);
        send(8'd2, 3'd0);
        wait_done();
        chk(rises - r0 == 130, "R6", "pulses for clamped chain", rises - r0, 130);

        // R8: idle pulses, five and zero
        req = "R8";
        clk_div = 8'd1;
        r0 = rises;
        push_bits(8'h00, 8'h00, 5, 1'b0);
        send(8'h0C, 3'd0);
        send(8'd5, 3'd0);
        wait_done();
        chk(rises - r0 == 5, "R8", "idle pulse count", rises - r0, 5);
        r0 = rises;
        send(8'h0C, 3'd0);
        send(8'd0, 3'd0);
        wait_done();
        chk(rises - r0 == 0, "R8", "zero idle pulses", rises - r0, 0);

        // R9: byte shift with TDO capture
        req = "R9";
        tdo_pat   = 8'hC5;
        rise_base = rises;
        c0 = rsp_count;
        @(negedge clk);
        push_bits(8'h00, 8'h3A, 8, 1'b0);
        send(8'h08, 3'd0);
        send(8'h3A, 3'd0);
        wait_done();
        chk(rsp_count - c0 == 1, "R9", "response pulses", rsp_count - c0, 1);
        chk(rsp_last == 8'hC5, "R9", "captured TDO byte", int'(rsp_last), 8'hC5);

        // R11: unknown opcodes are dropped, decoding continues
        req = "R11";
        r0 = rises;
        c0 = rsp_count;
        send(8'h00, 3'd0);
        send(8'h42, 3'd0);
        send(8'hFF, 3'd0);
        wait_done();
        chk(rises - r0 == 0, "R11", "pulses from unknown opcodes", rises - r0, 0);
        chk(rsp_count == c0, "R11", "responses from unknown opcodes", rsp_count - c0, 0);
        chk(busy == 1'b0, "R11", "busy after unknown opcodes", int'(busy), 0);
        push_bits(8'h05, 8'h00, 3, 1'b0);
        send(8'h09, 3'd0);
        send(8'h05, 3'd3);
        wait_done();
        chk(rises - r0 == 3, "R11", "move after unknown opcodes", rises - r0, 3);

        report();
    end

endmodule